// File: doc/BRIEF.md
# Five-Port Parallel I/O Controller

This block is a general-purpose parallel I/O unit that hangs off a simple processor I/O bus. It holds five 8-bit ports, numbered 0 to 4. Each port has an output latch and a direction register with one bit per pin. The processor reaches every register through an 8-bit I/O address. The latches and direction registers drive the pin outputs. A read of a port's data register returns a per-bit blend: input-pin values where the pin is an input, latched values where it is an output.

The data and direction registers do not form one contiguous block. The data registers of ports 0 to 2 are adjacent, and ports 3 and 4 each have a separate location. In every case the direction register sits four above its port's data register. Each port also gives a one-cycle write strobe, so that logic outside the block can act on a fresh output byte in the cycle it appears on the pins.

Top module: `pio5_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises with no write yet, every latch and every direction register reads as 0x00, `pin_out` and `pin_dir` are all zero, and no `port_wr_stb` bit is high. Every pin therefore starts as an input.
- R2: The data registers are at these addresses: port 0 at 0x50, port 1 at 0x51, port 2 at 0x52, port 3 at 0x30 and port 4 at 0x40. A clock edge with `bus_wr` high and `bus_addr` on a data register loads `bus_wdata` into that port's latch. From that edge on, the latch appears on `pin_out[8*k+7:8*k]` for port k.
- R3: Each port's direction register is at its data address plus 0x04: 0x54, 0x55, 0x56, 0x34 and 0x44. A write replaces all eight bits, the value appears on `pin_dir[8*k+7:8*k]`, and a read of the address returns the stored byte.
- R4: A read of port k's data address returns `(pin_in_k & ~dir_k) | (latch_k & dir_k)` bit by bit. A direction bit of 1 marks an output.
- R5: `port_wr_stb[k]` is high for exactly the one cycle that follows the edge that loaded port k's latch. Direction writes and writes to other ports leave it low.
- R6: A write to an address outside the ten listed changes no latch, direction register or strobe. A read of such an address returns 0xFF.
- R7: `bus_rdata` is combinational from `bus_addr` and the current register and pin state. During a write cycle, before the edge, it still shows the old contents.
- R8: A write to one port's register leaves the latches and direction registers of all other ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | I/O address for both reads and writes |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 40 | Input pins, port k in bits 8k+7..8k |
| pin_out | output | 40 | Latched output values, port k in bits 8k+7..8k |
| pin_dir | output | 40 | Direction bits (1 = output), port k in bits 8k+7..8k |
| port_wr_stb | output | 5 | One-cycle strobe per port after its latch is loaded |

## Verification
Read data has no register in its path. The bench therefore sets the address at a falling edge and checks `bus_rdata` one nanosecond later, in the same cycle. It also does this while `bus_wr` is high, to confirm that the old value is still shown before the edge. A write passes through exactly one register on its way to `pin_out`, `pin_dir` and the strobe. These outputs are checked at the falling edge after the loading rising edge. The strobe is checked once more at the next falling edge, which confirms that it lasts a single cycle.

// File: rtl/pio5_pkg.sv
package pio5_pkg;

    localparam int PIO_NPORT   = 5;
    localparam int PIO_AW      = 8;
    localparam int PIO_DIR_OFS = 4;

    // Data register location of port i; ports 0..2 are adjacent, 3 and 4 stand apart.
    function automatic logic [PIO_AW-1:0] pio_data_addr(input int i);
        case (i)
            0:       return 8'h50;
            1:       return 8'h51;
            2:       return 8'h52;
            3:       return 8'h30;
            default: return 8'h40;
        endcase
    endfunction

    // Direction register sits a fixed offset above the data register.
    function automatic logic [PIO_AW-1:0] pio_dir_addr(input int i);
        return pio_data_addr(i) + PIO_AW'(PIO_DIR_OFS);
    endfunction

    typedef struct packed {
        logic [PIO_NPORT-1:0] dat;
        logic [PIO_NPORT-1:0] dir;
    } pio_hit_t;

endpackage

// File: rtl/pio5_decode.sv
module pio5_decode
    import pio5_pkg::*;
(
    input  logic [PIO_AW-1:0] addr,
    output pio_hit_t          hit,
    output logic              any_hit
);
    for (genvar i = 0; i < PIO_NPORT; i++) begin : g_cmp
        assign hit.dat[i] = (addr == pio_data_addr(i));
        assign hit.dir[i] = (addr == pio_dir_addr(i));
    end

    assign any_hit = |{hit.dat, hit.dir};
endmodule

// File: rtl/pio5_port.sv
module pio5_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_dat,
    input  logic          wr_dir,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] latch_q,
    output logic [DW-1:0] dir_q,
    output logic          wr_stb,
    output logic [DW-1:0] rd_dat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            wr_stb  <= 1'b0;
        end else begin
            wr_stb <= wr_dat;
            if (wr_dat) latch_q <= wdata;
            if (wr_dir) dir_q   <= wdata;
        end
    end

    // Per-bit blend: outputs read back their latch, inputs read the pin.
    assign rd_dat = (pin_in & ~dir_q) | (latch_q & dir_q);

    assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dat |=> (latch_q == $past(wdata)));

    assert_dir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(wdata)));

    assert_strobe_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dat |=> wr_stb);

    assert_strobe_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dat |=> !wr_stb);

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dat |=> $stable(latch_q));

    assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));
endmodule

// File: rtl/pio5_ctrl.sv
module pio5_ctrl
    import pio5_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PIO_AW-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic [PIO_NPORT*DW-1:0] pin_in,
    output logic [PIO_NPORT*DW-1:0] pin_out,
    output logic [PIO_NPORT*DW-1:0] pin_dir,
    output logic [PIO_NPORT-1:0]    port_wr_stb
);
    localparam int NP = PIO_NPORT;

    pio_hit_t      hit;
    logic          any_hit;
    logic [DW-1:0] merged [NP];
    logic [DW-1:0] dir_v  [NP];

    pio5_decode u_dec (
        .addr    (bus_addr),
        .hit     (hit),
        .any_hit (any_hit)
    );

    for (genvar k = 0; k < NP; k++) begin : g_port
        logic [DW-1:0] lat_k;
        pio5_port #(.DW(DW)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_dat  (bus_wr & hit.dat[k]),
            .wr_dir  (bus_wr & hit.dir[k]),
            .wdata   (bus_wdata),
            .pin_in  (pin_in[k*DW +: DW]),
            .latch_q (lat_k),
            .dir_q   (dir_v[k]),
            .wr_stb  (port_wr_stb[k]),
            .rd_dat  (merged[k])
        );
        assign pin_out[k*DW +: DW] = lat_k;
        assign pin_dir[k*DW +: DW] = dir_v[k];
    end

    always_comb begin
        bus_rdata = '1;
        if (any_hit) begin
            for (int k = 0; k < NP; k++) begin
                if (hit.dat[k]) bus_rdata = merged[k];
                if (hit.dir[k]) bus_rdata = dir_v[k];
            end
        end
    end

    assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_wr_stb));

    assert_unmapped_nostrobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !any_hit) |=> (port_wr_stb == '0));

    assert_unmapped_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !any_hit) |=> ($stable(pin_out) && $stable(pin_dir)));
endmodule

// File: tb/pio5_ctrl_tb.sv
module pio5_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [39:0] pin_in;
    logic [39:0] pin_out;
    logic [39:0] pin_dir;
    logic [4:0]  port_wr_stb;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;
    logic [7:0] m_lat [5];
    logic [7:0] m_dir [5];

    always #2 clk = ~clk;

    pio5_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_dir(pin_dir), .port_wr_stb(port_wr_stb)
    );

    function automatic int data_idx(input logic [7:0] a);
        case (a)
            8'h50: return 0;
            8'h51: return 1;
            8'h52: return 2;
            8'h30: return 3;
            8'h40: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic int dir_idx(input logic [7:0] a);
        case (a)
            8'h54: return 0;
            8'h55: return 1;
            8'h56: return 2;
            8'h34: return 3;
            8'h44: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        int d = data_idx(a);
        int r = dir_idx(a);
        if (d >= 0) return (pin_in[d*8 +: 8] & ~m_dir[d]) | (m_lat[d] & m_dir[d]);
        if (r >= 0) return m_dir[r];
        return 8'hFF;
    endfunction

    function automatic logic [39:0] exp_out();
        logic [39:0] v;
        for (int k = 0; k < 5; k++) v[k*8 +: 8] = m_lat[k];
        return v;
    endfunction

    function automatic logic [39:0] exp_dirv();
        logic [39:0] v;
        for (int k = 0; k < 5; k++) v[k*8 +: 8] = m_dir[k];
        return v;
    endfunction

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, {32'd0, bus_rdata}, {32'd0, exp_read(a)});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        int di = data_idx(a);
        int ri = dir_idx(a);
        logic [4:0] stb;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 check("R7 old value during write", {32'd0, bus_rdata}, {32'd0, exp_read(a)});
        @(posedge clk);
        if (di >= 0) m_lat[di] = d;
        if (ri >= 0) m_dir[ri] = d;
        @(negedge clk);
        bus_wr = 1'b0;
        stb = (di >= 0) ? 5'(1 << di) : 5'd0;
        check("R5 strobe after edge", {35'd0, port_wr_stb}, {35'd0, stb});
        check("R2 R8 R6 pin_out", pin_out, exp_out());
        check("R3 R8 R6 pin_dir", pin_dir, exp_dirv());
        @(negedge clk);
        check("R5 strobe single cycle", {35'd0, port_wr_stb}, 40'd0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] maps [10];
        maps = '{8'h50, 8'h51, 8'h52, 8'h30, 8'h40, 8'h54, 8'h55, 8'h56, 8'h34, 8'h44};
        void'($urandom(32'd1234));
        for (int k = 0; k < 5; k++) begin m_lat[k] = 8'h00; m_dir[k] = 8'h00; end
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
        pin_in = 40'hC3_5A_96_3C_E1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pin_out in reset", pin_out, 40'd0);
        check("R1 pin_dir in reset", pin_dir, 40'd0);
        check("R1 strobe in reset", {35'd0, port_wr_stb}, 40'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 10; k++) do_read(maps[k], "R1 R4 read after reset");

        // directed corner cases
        do_write(8'h50, 8'hA5);
        do_read(8'h50, "R4 all inputs hide latch");
        do_write(8'h54, 8'h0F);
        do_read(8'h54, "R3 dir readback");
        do_read(8'h50, "R4 mixed merge");
        do_write(8'h44, 8'hFF);
        do_write(8'h40, 8'h3C);
        do_read(8'h40, "R4 all outputs return latch");
        do_write(8'h30, 8'h81);
        do_write(8'h34, 8'hF0);
        do_read(8'h30, "R2 port 3 merge");
        do_write(8'h53, 8'h77);
        do_write(8'h00, 8'h11);
        do_write(8'h57, 8'h22);
        do_read(8'h53, "R6 unmapped read");
        do_read(8'h31, "R6 unmapped read");
        do_read(8'hFF, "R6 unmapped read");

        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            logic [7:0] d;
            int op = int'($urandom % 4);
            if ($urandom % 5 == 0) a = 8'($urandom);
            else a = maps[$urandom % 10];
            d = 8'($urandom);
            if ($urandom % 6 == 0) pin_in = {8'($urandom), 32'($urandom)};
            if (op < 2) do_write(a, d);
            else do_read(a, "R4 R3 R6 random read");
        end

        for (int k = 0; k < 10; k++) do_read(maps[k], "R4 R3 final sweep");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule